// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Read Mode

This block is a first-in first-out buffer with independent write and read clocks. A write port takes a data word and a write enable and shows a write-ready flag. A read port takes a read enable and shows an output data register and a read-ready flag. Each flag is computed in its own port's clock domain. The opposite pointer reaches that domain Gray-coded, through a two-stage flip-flop synchronizer.

A static mode input selects one of two read behaviours. In standard mode the read-ready flag means that the array is not empty. A word moves into the output register only when a read is requested. In fall-through mode the read-ready flag means that the output register holds a word not yet consumed. The first stored word is loaded into the register without a request, and a read request consumes it. The mode may change only while reset is held. Depth is a power of two set by a parameter. One active-low asynchronous reset clears both domains.

Top module: `dual_clk_fifo`

## Requirements
- R1: While reset is held and after it is released with no writes, `rrdy_o` is 0 and `wrdy_o` is 1.
- R2: A write with `wen_i` = 1 at a write-clock rising edge while `wrdy_o` = 1 stores `wdata_i`. The write pointer then advances by one Gray step.
- R3: `wrdy_o` is 0 once DEPTH words are stored. A write made while `wrdy_o` = 0 is dropped and never appears at the read side.
- R4: A read from a full FIFO frees one location. `wrdy_o` stays 0 after the first write-clock rising edge that follows that read and is 1 after the second.
- R5: With `fwft_i` = 0, a word written into an empty FIFO makes `rrdy_o` 1 at the second read-clock rising edge after the write, and not before.
- R6: With `fwft_i` = 0, `rdata_o` changes only at a read-clock edge where `ren_i` = 1 and `rrdy_o` = 1. A read while `rrdy_o` = 0 leaves `rdata_o` unchanged.
- R7: With `fwft_i` = 1, a word written into an empty FIFO reaches `rdata_o` at the third read-clock rising edge after the write. `rrdy_o` becomes 1 at that same edge, and both are still 0 and unloaded after the second edge.
- R8: With `fwft_i` = 1, `rrdy_o` = 1 together with `ren_i` = 0 holds `rdata_o` and `rrdy_o`. A read with `rrdy_o` = 1 loads the next stored word, or drops `rrdy_o` to 0 when none remains. A read while `rrdy_o` = 0 leaves `rdata_o` unchanged.
- R9: Words leave in the order they were accepted, in both modes. Writes and reads running concurrently in their own domains lose no word, and the read pointer advances by at most one per read-clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| fwft_i | input | 1 | Mode select: 1 fall-through, 0 standard; static outside reset |
| wdata_i | input | DW | Write data |
| wen_i | input | 1 | Write enable |
| wrdy_o | output | 1 | Write ready: 1 when a free location exists |
| ren_i | input | 1 | Read enable |
| rdata_o | output | DW | Output data register |
| rrdy_o | output | 1 | Read ready: not-empty (standard) or word valid (fall-through) |

## Verification
The assertions assume that `fwft_i` changes only while `rst_ni` is low, so each mode-dependent hold property sees one fixed mode between resets. They also assume that both clocks run while reset is released. The bench changes mode only inside its reset task and keeps the two clocks free-running at a fixed phase offset. It drives each input half a period away from the edge of its own domain, so every latency check samples a known number of synchronizer edges after the event.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } mode_e;
endpackage

// File: rtl/fifo_sync.sv
module fifo_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[i] <= '0;
        else         st_q[i] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[i] <= '0;
        else         st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/fifo_mem.sv
module fifo_mem #(
  parameter int AW = 3,
  parameter int DW = 16
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int N = 1 << AW;
  logic [DW-1:0] mem_q [N];

  always_ff @(posedge wclk_i)
    if (we_i) mem_q[waddr_i] <= wdata_i;

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl #(
  parameter int AW = 3
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          wen_i,
  input  logic [AW:0]   rgray_s_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wbin_o,
  output logic [AW:0]   wgray_o,
  output logic          wrdy_o
);
  logic [AW:0] wbin_q, wgray_q, wbin_nx;
  logic        full;

  function automatic logic [AW:0] to_gray(logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  // full: top two Gray bits inverted, rest equal
  assign full    = (wgray_q == {~rgray_s_i[AW:AW-1], rgray_s_i[AW-2:0]});
  assign we_o    = wen_i && !full;
  assign wbin_nx = wbin_q + {{AW{1'b0}}, 1'b1};

  always_ff @(posedge wclk_i or negedge rst_ni)
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (we_o) begin
      wbin_q  <= wbin_nx;
      wgray_q <= to_gray(wbin_nx);
    end

  assign waddr_o = wbin_q[AW-1:0];
  assign wbin_o  = wbin_q;
  assign wgray_o = wgray_q;
  assign wrdy_o  = !full;
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl
  import fifo_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 16
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  mode_e         mode_i,
  input  logic          ren_i,
  input  logic [AW:0]   wgray_s_i,
  input  logic [DW-1:0] mem_q_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rbin_o,
  output logic [AW:0]   rgray_o,
  output logic [DW-1:0] rdata_o,
  output logic          rrdy_o
);
  logic [AW:0]   rbin_q, rgray_q, rbin_nx;
  logic [DW-1:0] rdata_q;
  logic          valid_q, avail, load;

  function automatic logic [AW:0] to_gray(logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  assign avail   = (rgray_q != wgray_s_i);
  assign rbin_nx = rbin_q + {{AW{1'b0}}, 1'b1};

  always_comb begin
    if (mode_i == MODE_FWFT) load = avail && (!valid_q || ren_i);
    else                     load = avail && ren_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni)
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      rdata_q <= '0;
    end else if (load) begin
      rbin_q  <= rbin_nx;
      rgray_q <= to_gray(rbin_nx);
      rdata_q <= mem_q_i;
    end

  // output-register valid, used in fall-through mode only
  always_ff @(posedge rclk_i or negedge rst_ni)
    if (!rst_ni)    valid_q <= 1'b0;
    else if (load)  valid_q <= 1'b1;
    else if (ren_i) valid_q <= 1'b0;

  assign raddr_o = rbin_q[AW-1:0];
  assign rbin_o  = rbin_q;
  assign rgray_o = rgray_q;
  assign rdata_o = rdata_q;
  assign rrdy_o  = (mode_i == MODE_FWFT) ? valid_q : avail;
endmodule

// File: rtl/dual_clk_fifo.sv
module dual_clk_fifo
  import fifo_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wen_i,
  output logic          wrdy_o,
  input  logic          ren_i,
  output logic [DW-1:0] rdata_o,
  output logic          rrdy_o
);
  localparam int AW     = $clog2(DEPTH);
  localparam int SYNC_N = 2;

  mode_e         mode;
  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wbin, wgray, rbin, rgray, wgray_s, rgray_s;
  logic [DW-1:0] mem_q;

  assign mode = fwft_i ? MODE_FWFT : MODE_STD;

  fifo_wr_ctl #(.AW(AW)) u_wr (
    .wclk_i(wclk_i), .rst_ni(rst_ni), .wen_i(wen_i), .rgray_s_i(rgray_s),
    .we_o(we), .waddr_o(waddr), .wbin_o(wbin), .wgray_o(wgray), .wrdy_o(wrdy_o)
  );

  fifo_mem #(.AW(AW), .DW(DW)) u_mem (
    .wclk_i(wclk_i), .we_i(we), .waddr_i(waddr), .wdata_i(wdata_i),
    .raddr_i(raddr), .rdata_o(mem_q)
  );

  fifo_sync #(.W(AW+1), .STAGES(SYNC_N)) u_sync_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray), .q_o(wgray_s)
  );

  fifo_sync #(.W(AW+1), .STAGES(SYNC_N)) u_sync_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray), .q_o(rgray_s)
  );

  fifo_rd_ctl #(.AW(AW), .DW(DW)) u_rd (
    .rclk_i(rclk_i), .rst_ni(rst_ni), .mode_i(mode), .ren_i(ren_i),
    .wgray_s_i(wgray_s), .mem_q_i(mem_q), .raddr_o(raddr), .rbin_o(rbin),
    .rgray_o(rgray), .rdata_o(rdata_o), .rrdy_o(rrdy_o)
  );
endmodule

// File: rtl/fifo_chk.sv
module fifo_chk #(
  parameter int AW = 3,
  parameter int DW = 16
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          fwft_i,
  input logic          wen_i,
  input logic          wrdy_o,
  input logic          ren_i,
  input logic          rrdy_o,
  input logic [DW-1:0] rdata_o,
  input logic [AW:0]   wbin,
  input logic [AW:0]   wgray,
  input logic [AW:0]   rbin
);
  p_gray_step_r2: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $onehot0(wgray ^ $past(wgray)));

  p_drop_full_r3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wen_i && !wrdy_o) |=> $stable(wbin));

  p_std_hold_r6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!fwft_i && !rrdy_o) |=> $stable(rdata_o));

  p_fwft_hold_r8: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (fwft_i && rrdy_o && !ren_i) |=> (rrdy_o && $stable(rdata_o)));

  p_rptr_step_r9: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rbin == $past(rbin)) || (rbin == ($past(rbin) + {{AW{1'b0}}, 1'b1})));
endmodule

bind dual_clk_fifo fifo_chk #(.AW(AW), .DW(DW)) u_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni), .fwft_i(fwft_i),
  .wen_i(wen_i), .wrdy_o(wrdy_o), .ren_i(ren_i), .rrdy_o(rrdy_o),
  .rdata_o(rdata_o), .wbin(wbin), .wgray(wgray), .rbin(rbin)
);

// File: tb/tb_dual_clk_fifo.sv
`timescale 1ns/1ps
module tb_dual_clk_fifo;
  localparam int DW    = 16;
  localparam int DEPTH = 8;
  localparam int NV    = 6;
  // vector: {fwft, count[7:0], base[15:0]}
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'd1, 16'h1000},
    {1'b0, 8'd5, 16'h2200},
    {1'b0, 8'd8, 16'h3300},
    {1'b1, 8'd1, 16'h4400},
    {1'b1, 8'd6, 16'h5500},
    {1'b1, 8'd8, 16'h6600}
  };

  logic wclk = 0, rclk = 0, rst_n = 0, fwft = 0, wen = 0, ren = 0;
  logic [DW-1:0] wdata = '0;
  logic wrdy, rrdy;
  logic [DW-1:0] rdata;
  int n_run = 0, n_fail = 0;

  dual_clk_fifo #(.DW(DW), .DEPTH(DEPTH)) dut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .fwft_i(fwft),
    .wdata_i(wdata), .wen_i(wen), .wrdy_o(wrdy), .ren_i(ren),
    .rdata_o(rdata), .rrdy_o(rrdy)
  );

  always #2.5 wclk = ~wclk;
  initial begin
    #1.25;
    forever begin rclk = 1; #2.5; rclk = 0; #2.5; end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 0; wen = 0; ren = 0;
    repeat (3) @(negedge wclk);
    fwft = mode;
    repeat (2) @(negedge wclk);
    rst_n = 1;
    @(negedge wclk);
  endtask

  task automatic push(input logic [DW-1:0] d);
    do @(negedge wclk); while (!wrdy);
    wdata = d; wen = 1;
    @(posedge wclk); #0.5 wen = 0;
  endtask

  task automatic push_raw(input logic [DW-1:0] d);
    @(negedge wclk);
    wdata = d; wen = 1;
    @(posedge wclk); #0.5 wen = 0;
  endtask

  // standard mode: wait not empty, read, return loaded word
  task automatic pop_std(output logic [DW-1:0] v);
    do @(negedge rclk); while (!rrdy);
    ren = 1;
    @(posedge rclk); #0.5 ren = 0;
    @(negedge rclk);
    v = rdata;
  endtask

  // fall-through mode: wait valid, take word, consume
  task automatic pop_fwft(output logic [DW-1:0] v);
    do @(negedge rclk); while (!rrdy);
    v = rdata;
    ren = 1;
    @(posedge rclk); #0.5 ren = 0;
  endtask

  initial begin
    repeat (50000) @(posedge wclk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] v, held;
    // R1 reset state
    #1;
    chk(rrdy == 1'b0, "R1 rrdy in reset", int'(rrdy), 0);
    chk(wrdy == 1'b1, "R1 wrdy in reset", int'(wrdy), 1);
    do_reset(1'b0);
    chk(rrdy == 1'b0 && wrdy == 1'b1, "R1 flags after reset", int'({rrdy, wrdy}), 1);

    // table walk: ordered transfer in both modes (R2, R9)
    for (int k = 0; k < NV; k++) begin
      logic md;
      int cnt;
      logic [DW-1:0] base;
      md = VEC[k][24]; cnt = int'(VEC[k][23:16]); base = VEC[k][15:0];
      do_reset(md);
      for (int i = 0; i < cnt; i++) push(base + DW'(i));
      repeat (6) @(negedge rclk);
      for (int i = 0; i < cnt; i++) begin
        if (md) pop_fwft(v); else pop_std(v);
        chk(v == base + DW'(i), "R9 order", int'(v), int'(base + DW'(i)));
      end
      @(negedge rclk);
      chk(rrdy == 1'b0, "R2 drained", int'(rrdy), 0);
    end

    // R5 standard latency
    do_reset(1'b0);
    push(16'hA5A5);
    @(negedge rclk);
    @(negedge rclk);
    chk(rrdy == 1'b0, "R5 after 1st edge", int'(rrdy), 0);
    @(negedge rclk);
    chk(rrdy == 1'b1, "R5 after 2nd edge", int'(rrdy), 1);
    // R6 nothing loaded without a read
    chk(rdata == '0, "R6 no load without read", int'(rdata), 0);
    pop_std(v);
    chk(v == 16'hA5A5, "R6 read loads word", int'(v), 16'hA5A5);
    // R6 read while empty ignored
    @(negedge rclk); ren = 1;
    @(posedge rclk); #0.5 ren = 0;
    @(negedge rclk);
    chk(rdata == 16'hA5A5 && rrdy == 1'b0, "R6 empty read ignored", int'(rdata), 16'hA5A5);

    // R7 fall-through latency
    do_reset(1'b1);
    push(16'h7E57);
    @(negedge rclk);
    @(negedge rclk);
    @(negedge rclk);
    chk(rrdy == 1'b0 && rdata == '0, "R7 after 2nd edge", int'(rdata), 0);
    @(negedge rclk);
    chk(rrdy == 1'b1, "R7 rrdy at 3rd edge", int'(rrdy), 1);
    chk(rdata == 16'h7E57, "R7 data at 3rd edge", int'(rdata), 16'h7E57);

    // R8 hold, advance, underrun ignored
    push(16'h0B0B);
    repeat (6) @(negedge rclk);
    chk(rrdy == 1'b1 && rdata == 16'h7E57, "R8 held without read", int'(rdata), 16'h7E57);
    ren = 1; @(posedge rclk); #0.5 ren = 0;
    @(negedge rclk);
    chk(rrdy == 1'b1 && rdata == 16'h0B0B, "R8 next word", int'(rdata), 16'h0B0B);
    ren = 1; @(posedge rclk); #0.5 ren = 0;
    @(negedge rclk);
    chk(rrdy == 1'b0, "R8 drop when none left", int'(rrdy), 0);
    held = rdata;
    ren = 1; @(posedge rclk); #0.5 ren = 0;
    @(negedge rclk);
    chk(rrdy == 1'b0 && rdata == held, "R8 read while not ready", int'(rdata), int'(held));

    // R3 full and overflow drop, R4 release latency
    do_reset(1'b0);
    for (int i = 0; i < DEPTH; i++) push(16'hC000 + DW'(i));
    repeat (3) @(negedge wclk);
    chk(wrdy == 1'b0, "R3 full flag", int'(wrdy), 0);
    push_raw(16'hDEAD);
    repeat (4) @(negedge rclk);
    @(negedge rclk); ren = 1;
    @(posedge rclk); #0.5 ren = 0;
    @(negedge wclk);
    chk(wrdy == 1'b0, "R4 after 1st write edge", int'(wrdy), 0);
    @(negedge wclk);
    chk(wrdy == 1'b1, "R4 after 2nd write edge", int'(wrdy), 1);
    @(negedge rclk);
    chk(rdata == 16'hC000, "R4 first word read", int'(rdata), 16'hC000);
    for (int i = 1; i < DEPTH; i++) begin
      pop_std(v);
      chk(v == 16'hC000 + DW'(i), "R3 stored words", int'(v), int'(16'hC000 + DW'(i)));
    end
    repeat (6) @(negedge rclk);
    chk(rrdy == 1'b0, "R3 overflow word dropped", int'(rrdy), 0);

    // R9 concurrent traffic, both modes
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      fork
        for (int i = 0; i < 24; i++) push(16'h9000 + DW'(i));
        for (int i = 0; i < 24; i++) begin
          logic [DW-1:0] r;
          if (m == 1) pop_fwft(r); else pop_std(r);
          chk(r == 16'h9000 + DW'(i), "R9 concurrent", int'(r), int'(16'h9000 + DW'(i)));
        end
      join
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule